// File: doc/BRIEF.md
# Ingress Timestamp Capture Unit

This block stamps each packet arriving on a streaming receive interface with the time at which it crossed the network medium. On the beat that carries start-of-packet it samples two time-of-day values supplied by an external time counter. One is a seconds-plus-nanoseconds form; the other is a flat nanoseconds form. It removes from both the residence delay of the physical layer, which the PHY reports as a fixed-point count of clock cycles.

The cycle count is turned into nanoseconds by multiplying it with a parameterised clock period. That period is held in nanoseconds with 16 fractional bits. The block subtracts the result from each time value. In the seconds form, a nanosecond underflow borrows one second. In the flat form, the value wraps modulo 2^64. There is one register stage: both stamps, their valid strobes and a delayed copy of start-of-packet leave the block together, one clock after the start-of-packet input. The delayed start-of-packet lets the datapath stay aligned with the stamps.

Top module: `ptp_ingr_stamp`

## Requirements
- R1: When `rx_sop` is high at a clock edge, `sop_dly`, `stamp96_valid` and `stamp64_valid` are all high after that edge, for exactly one cycle per start-of-packet beat.
- R2: The 96-bit time input and stamp use the same layout: seconds in bits 95:48, nanoseconds in bits 47:16 and fractional nanoseconds (1/65536 ns) in bits 15:0.
- R3: The 64-bit time input and stamp use the same layout: nanoseconds in bits 63:16 and fractional nanoseconds in bits 15:0.
- R4: `phy_delay` holds a fraction of a clock cycle in bits 9:0 and whole cycles in bits DLY_W-1:10. The delay that is removed equals floor(`phy_delay` × PERIOD_Q16 / 1024), in units of 1/65536 ns.
- R5: `stamp96` is the sampled 96-bit time minus the delay. If the nanosecond/fraction part would go negative, 1,000,000,000 ns is added to it and seconds is reduced by one, wrapping modulo 2^48. A nanosecond field below 10^9 stays below 10^9.
- R6: `stamp64` is the sampled 64-bit time minus the delay, modulo 2^64.
- R7: In a cycle that follows an edge where `rx_sop` was low, all three strobes are low and both stamps keep their previous values, whatever the other inputs carried.
- R8: A synchronous active-high `rst` clears both strobes, `sop_dly` and both stamps to zero.
- R9: With `phy_delay` equal to zero, both stamps equal the sampled time inputs exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_sop | input | 1 | Start-of-packet of the receive stream |
| tod_secns | input | 96 | Time of day, seconds/ns/fraction form |
| tod_ns | input | 64 | Time of day, ns/fraction form |
| phy_delay | input | DLY_W | PHY residence delay, cycles with 10 fractional bits |
| sop_dly | output | 1 | Start-of-packet delayed by one cycle |
| stamp96_valid | output | 1 | Qualifies `stamp96` |
| stamp96 | output | 96 | Compensated seconds/ns/fraction stamp |
| stamp64_valid | output | 1 | Qualifies `stamp64` |
| stamp64 | output | 64 | Compensated ns/fraction stamp |

## Verification
On every cycle, the assertions check four things. The strobes follow start-of-packet with exactly one cycle of delay. The stamps hold between packets. A zero delay passes both time values through unchanged. A legal nanosecond field stays legal after the seconds borrow. The exact arithmetic can only be shown by the bench's scenarios, which compare against reference values: the cycle-to-nanosecond scaling and truncation, the borrow into seconds including the wrap of seconds from zero, the wrap of the flat form, and the reset values.

// File: rtl/ptp_ingr_pkg.sv
package ptp_ingr_pkg;
   localparam int SECNS_W  = 96;
   localparam int FLAT_W   = 64;
   localparam int SEC_W    = 48;
   localparam int NS_W     = 32;
   localparam int FRAC_W   = 16;
   localparam int DQ_W     = 48;   // delay in ns, Q16, also ns+frac width of 96b form
   localparam int DLY_FRAC = 10;   // fractional cycle bits of the PHY delay
   localparam logic [31:0] NS_PER_SEC     = 32'd1_000_000_000;
   localparam logic [47:0] NS_PER_SEC_Q16 = 48'd65_536_000_000_000;
endpackage

// File: rtl/ptp_dly_to_ns.sv
module ptp_dly_to_ns
   import ptp_ingr_pkg::*;
#(
   parameter int          DLY_W      = 22,
   parameter logic [31:0] PERIOD_Q16 = 32'd419430
) (
   input  logic [DLY_W-1:0] phy_delay,
   output logic [DQ_W-1:0]  dly_q16
);
   localparam int PW = DLY_W + 32;

   logic [PW-1:0] prod;

   // cycles(Q10) * period(Q16 ns) = ns in Q26; drop 10 bits to reach Q16
   assign prod    = PW'(phy_delay) * PW'(PERIOD_Q16);
   assign dly_q16 = DQ_W'(prod >> DLY_FRAC);
endmodule

// File: rtl/ptp_sub_secns.sv
module ptp_sub_secns
   import ptp_ingr_pkg::*;
(
   input  logic [SECNS_W-1:0] tod,
   input  logic [DQ_W-1:0]    dly_q16,
   output logic [SECNS_W-1:0] stamp
);
   logic [SEC_W-1:0] sec_in;
   logic [DQ_W-1:0]  nsf_in;
   logic [DQ_W-1:0]  diff;
   logic             borrow;

   assign sec_in = tod[SECNS_W-1 -: SEC_W];
   assign nsf_in = tod[DQ_W-1:0];
   assign borrow = (nsf_in < dly_q16);
   assign diff   = nsf_in - dly_q16;

   always_comb begin
      if (borrow) begin
         stamp[SECNS_W-1 -: SEC_W] = sec_in - SEC_W'(1);
         stamp[DQ_W-1:0]           = diff + NS_PER_SEC_Q16;
      end else begin
         stamp[SECNS_W-1 -: SEC_W] = sec_in;
         stamp[DQ_W-1:0]           = diff;
      end
   end
endmodule

// File: rtl/ptp_sub_flat.sv
module ptp_sub_flat
   import ptp_ingr_pkg::*;
(
   input  logic [FLAT_W-1:0] tod,
   input  logic [DQ_W-1:0]   dly_q16,
   output logic [FLAT_W-1:0] stamp
);
   // plain modulo-2^64 subtraction; the flat form has no carry field
   assign stamp = tod - FLAT_W'(dly_q16);
endmodule

// File: rtl/ptp_ingr_stamp.sv
module ptp_ingr_stamp
   import ptp_ingr_pkg::*;
#(
   parameter int          DLY_W      = 22,
   parameter logic [31:0] PERIOD_Q16 = 32'd419430
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               rx_sop,
   input  logic [SECNS_W-1:0] tod_secns,
   input  logic [FLAT_W-1:0]  tod_ns,
   input  logic [DLY_W-1:0]   phy_delay,
   output logic               sop_dly,
   output logic               stamp96_valid,
   output logic [SECNS_W-1:0] stamp96,
   output logic               stamp64_valid,
   output logic [FLAT_W-1:0]  stamp64
);
   localparam logic [63:0] MAX_DLY_Q16 =
      ((64'd1 << (DLY_W - DLY_FRAC)) * 64'(PERIOD_Q16));

   generate
      if (!(DLY_W == 16 || DLY_W == 22 || DLY_W == 24)) begin : g_bad_w
         $error("phy_delay width must be 16, 22 or 24");
      end
      if (MAX_DLY_Q16 >= 64'(NS_PER_SEC_Q16)) begin : g_bad_period
         $error("largest delay must stay below one second");
      end
      if (PERIOD_Q16 == 32'd0) begin : g_zero_period
         $error("clock period must be non-zero");
      end
   endgenerate

   logic [DQ_W-1:0]    dly_q16;
   logic [SECNS_W-1:0] nxt96;
   logic [FLAT_W-1:0]  nxt64;

   ptp_dly_to_ns #(.DLY_W(DLY_W), .PERIOD_Q16(PERIOD_Q16)) u_conv (
      .phy_delay (phy_delay),
      .dly_q16   (dly_q16)
   );

   ptp_sub_secns u_sub96 (
      .tod     (tod_secns),
      .dly_q16 (dly_q16),
      .stamp   (nxt96)
   );

   ptp_sub_flat u_sub64 (
      .tod     (tod_ns),
      .dly_q16 (dly_q16),
      .stamp   (nxt64)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sop_dly       <= 1'b0;
         stamp96_valid <= 1'b0;
         stamp64_valid <= 1'b0;
         stamp96       <= '0;
         stamp64       <= '0;
      end else begin
         sop_dly       <= rx_sop;
         stamp96_valid <= rx_sop;
         stamp64_valid <= rx_sop;
         if (rx_sop) begin
            stamp96 <= nxt96;
            stamp64 <= nxt64;
         end
      end
   end
endmodule

// File: rtl/ptp_ingr_stamp_chk.sv
module ptp_ingr_stamp_chk
   import ptp_ingr_pkg::*;
#(
   parameter int DLY_W = 22
) (
   input logic               clk,
   input logic               rst,
   input logic               rx_sop,
   input logic [SECNS_W-1:0] tod_secns,
   input logic [FLAT_W-1:0]  tod_ns,
   input logic [DLY_W-1:0]   phy_delay,
   input logic               sop_dly,
   input logic               stamp96_valid,
   input logic [SECNS_W-1:0] stamp96,
   input logic               stamp64_valid,
   input logic [FLAT_W-1:0]  stamp64
);
   AST_STROBES_FOLLOW_SOP: assert property (@(posedge clk) disable iff (rst)
      rx_sop |=> (sop_dly && stamp96_valid && stamp64_valid));  // R1

   AST_STROBES_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
      !rx_sop |=> (!sop_dly && !stamp96_valid && !stamp64_valid));  // R7

   AST_STAMPS_HELD: assert property (@(posedge clk) disable iff (rst)
      !rx_sop |=> ($stable(stamp96) && $stable(stamp64)));  // R7

   AST_ZERO_DLY_SECNS: assert property (@(posedge clk) disable iff (rst)
      (rx_sop && phy_delay == '0) |=> (stamp96 == $past(tod_secns)));  // R9

   AST_ZERO_DLY_FLAT: assert property (@(posedge clk) disable iff (rst)
      (rx_sop && phy_delay == '0) |=> (stamp64 == $past(tod_ns)));  // R9

   AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      (rx_sop && tod_secns[47:16] < NS_PER_SEC) |=> (stamp96[47:16] < NS_PER_SEC));  // R5
endmodule

bind ptp_ingr_stamp ptp_ingr_stamp_chk #(.DLY_W(DLY_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .rx_sop        (rx_sop),
   .tod_secns     (tod_secns),
   .tod_ns        (tod_ns),
   .phy_delay     (phy_delay),
   .sop_dly       (sop_dly),
   .stamp96_valid (stamp96_valid),
   .stamp96       (stamp96),
   .stamp64_valid (stamp64_valid),
   .stamp64       (stamp64)
);

// File: tb/test_ptp_ingr_stamp.sv
`timescale 1ns/1ps
module test_ptp_ingr_stamp;
   localparam int          DLY_W  = 22;
   localparam logic [31:0] PERIOD = 32'd419430;   // 6.4 ns in Q16
   localparam logic [47:0] SEC_Q16 = 48'd65_536_000_000_000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              rx_sop = 1'b0;
   logic [95:0]       tod_secns = '0;
   logic [63:0]       tod_ns = '0;
   logic [DLY_W-1:0]  phy_delay = '0;
   logic              sop_dly, stamp96_valid, stamp64_valid;
   logic [95:0]       stamp96;
   logic [63:0]       stamp64;

   int n_run = 0;
   int n_fail = 0;
   logic [95:0] exp96 = '0;
   logic [63:0] exp64 = '0;

   ptp_ingr_stamp #(.DLY_W(DLY_W), .PERIOD_Q16(PERIOD)) i_ptp_ingr_stamp (
      .clk(clk), .rst(rst), .rx_sop(rx_sop), .tod_secns(tod_secns),
      .tod_ns(tod_ns), .phy_delay(phy_delay), .sop_dly(sop_dly),
      .stamp96_valid(stamp96_valid), .stamp96(stamp96),
      .stamp64_valid(stamp64_valid), .stamp64(stamp64)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   // R4: floor(delay * period / 1024) in Q16 ns
   function automatic logic [47:0] ref_dly(input logic [DLY_W-1:0] d);
      logic [63:0] p;
      p = 64'(d) * 64'(PERIOD);
      return 48'(p >> 10);
   endfunction

   // R2, R5
   function automatic logic [95:0] ref96(input logic [95:0] t, input logic [DLY_W-1:0] d);
      logic [47:0] dq, nsf, sec;
      dq  = ref_dly(d);
      nsf = t[47:0];
      sec = t[95:48];
      if (nsf >= dq) return {sec, nsf - dq};
      return {sec - 48'd1, nsf + SEC_Q16 - dq};
   endfunction

   // R3, R6
   function automatic logic [63:0] ref64(input logic [63:0] t, input logic [DLY_W-1:0] d);
      return t - 64'(ref_dly(d));
   endfunction

   task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [95:0] rnd_secns();
      logic [47:0] s;
      s = {$urandom(), $urandom()};
      return {s, 32'($urandom() % 32'd1_000_000_000), 16'($urandom())};
   endfunction

   // one cycle: drive at negedge, observe after the next rising edge
   task automatic step(input logic sop, input logic [95:0] t96, input logic [63:0] t64,
                       input logic [DLY_W-1:0] d, input string tag);
      @(negedge clk);
      rx_sop = sop; tod_secns = t96; tod_ns = t64; phy_delay = d;
      if (sop) begin
         exp96 = ref96(t96, d);
         exp64 = ref64(t64, d);
      end
      @(posedge clk);
      #1;
      check({tag, " R1/R7 strobes"}, {93'd0, sop_dly, stamp96_valid, stamp64_valid},
            {93'd0, sop, sop, sop});
      check({tag, " stamp96"}, stamp96, exp96);
      check({tag, " stamp64"}, {32'd0, stamp64}, {32'd0, exp64});
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R8: reset values
      check("R8 reset strobes", {93'd0, sop_dly, stamp96_valid, stamp64_valid}, 96'd0);
      check("R8 reset stamp96", stamp96, 96'd0);
      check("R8 reset stamp64", {32'd0, stamp64}, 96'd0);
      @(negedge clk);
      rst = 1'b0;

      // R9: zero delay passes time through
      step(1'b1, {48'd77, 32'd123456789, 16'h8000}, 64'h0000_1234_5678_9abc, '0, "R9 zero delay");
      // R7: idle cycles with changing inputs keep stamps
      step(1'b0, rnd_secns(), {$urandom(), $urandom()}, 22'h3fffff, "R7 idle");
      step(1'b0, rnd_secns(), {$urandom(), $urandom()}, 22'h000400, "R7 idle");
      // R4: one whole cycle = 6.4 ns, fraction only, truncation
      step(1'b1, {48'd5, 32'd1000, 16'd0}, 64'd1_000_000, 22'h000400, "R4 one cycle");
      step(1'b1, {48'd5, 32'd1000, 16'd0}, 64'd1_000_000, 22'h000001, "R4 fraction");
      step(1'b1, {48'd5, 32'd1000, 16'd0}, 64'd1_000_000, 22'h3fffff, "R4 max delay");
      // R5: borrow into seconds
      step(1'b1, {48'd9, 32'd0, 16'd0}, 64'd0, 22'h000c00, "R5/R6 borrow and wrap");
      step(1'b1, {48'd0, 32'd3, 16'd5}, 64'd3, 22'h001000, "R5 seconds wrap");
      step(1'b1, {48'd2, 32'd999_999_999, 16'hffff}, 64'hffff_ffff_ffff_ffff, 22'h000801, "R5 top of second");
      // R1: back-to-back start-of-packet beats
      step(1'b1, rnd_secns(), {$urandom(), $urandom()}, 22'($urandom()), "R1 back-to-back");
      step(1'b1, rnd_secns(), {$urandom(), $urandom()}, 22'($urandom()), "R1 back-to-back");

      // R2/R3/R5/R6: random mix
      for (int i = 0; i < 400; i++) begin
         step(($urandom() % 3) != 0, rnd_secns(), {$urandom(), $urandom()},
              22'($urandom()), "R2/R3/R6 random");
      end

      // R8: reset mid-run clears held stamps
      @(negedge clk);
      rst = 1'b1; rx_sop = 1'b1;
      @(posedge clk);
      #1;
      check("R8 mid-run strobes", {93'd0, sop_dly, stamp96_valid, stamp64_valid}, 96'd0);
      check("R8 mid-run stamp96", stamp96, 96'd0);
      check("R8 mid-run stamp64", {32'd0, stamp64}, 96'd0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule